// File: doc/BRIEF.md
# Asynchronous SRAM Write Timing Monitor

This block watches an asynchronous SRAM bus from the side and judges every write against the minimum intervals of a chosen speed grade. It drives nothing on the bus. A fast sample clock registers the address, the data, the chip-select strobe and the write strobe. A free-running tick counter stamps every edge of interest. A write is open while both active-low strobes are low. The monitor finds where each write opens and closes, measures the intervals around it in whole ticks, and compares each one with its limit.

Each rule has its own sticky flag and a one-cycle pulse. A saturating counter totals the violations, and a clear input wipes the flags and the counter. The monitor also records which strobe or strobes closed the last write. Recovery after a write can be satisfied in two ways: by the write strobe with a short margin or by the chip-select strobe with a longer one. A recovery violation is raised only when neither way is met. The monitor is built from parameters for the grade (0..3), the sample clock period in picoseconds, the bus widths, the timestamp width and the counter width.

Top module: `sram_wr_timing_mon`

## Requirements
- R1: After reset, and on the cycle after `clr` is high, `err_flag`, `err_pulse` and `err_count` are zero. `end_style` is zero after reset.
- R2: A write opens on the sample where the later of `bus_ce_n` and `bus_we_n` is first seen low. It closes on the sample where the earlier of the two is first seen high. `end_style` then holds {chip-select rose, write strobe rose} for that close: bit 1 for chip-select, bit 0 for write strobe, 2'b11 when both rise together.
- R3: Bit 0 flags a write whose open-to-close interval in ticks is below the pulse-width limit (grade 0..3: 55/65/90/130 ns).
- R4: Bit 1 flags a write whose data last changed fewer ticks before the close than the setup limit (30/35/50/70 ns).
- R5: Bit 2 flags a data change sampled in the same tick as the close, which breaks the zero hold time. Such a change does not count against the setup rule.
- R6: Bit 3 flags an address change between two samples that both have the write open.
- R7: Bit 4 flags an address change after a write when the write strobe has not been high for the 5 ns limit and the chip-select strobe has not been high for the 15 ns limit. Meeting either one suffices.
- R8: Bit 5 flags an address change that ends a cycle holding a write when the time since the previous address change is below the cycle limit (70/85/150/200 ns).
- R9: Bit 6 flags a close that comes fewer ticks after the last address change than the address-valid limit (65/75/90/150 ns).
- R10: Bit 7 flags a close that comes fewer ticks after the last chip-select fall than the chip-select limit (65/75/100/150 ns).
- R11: A flag stays set until `clr`. Each violation also gives a one-cycle `err_pulse` bit. `err_count` adds one per violation and saturates at all ones.
- R12: Every limit is the nanosecond value rounded up to whole ticks of `CLK_PS`. A write that meets every limit raises no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low reset |
| clr | input | 1 | Clears flags, pulses and counter |
| bus_addr | input | ADDR_W | Observed address |
| bus_data | input | DATA_W | Observed data |
| bus_ce_n | input | 1 | Observed chip-select strobe, active low |
| bus_we_n | input | 1 | Observed write strobe, active low |
| err_flag | output | 8 | Sticky violation flags, bit order as in R3..R10 |
| err_pulse | output | 8 | One-cycle violation indication |
| err_count | output | CNT_W | Saturating violation count |
| end_style | output | 2 | Strobes that closed the last write |

## Verification
Two pairs of events can land on the same sample. A write can close on the same sample as an address change, and a write can close on the same sample as a data change. The bench causes each pair on purpose. When the address moves on the closing sample, it expects only the recovery flag: the cycle time and the address-valid time must still be measured from the earlier address change. When the data moves on the closing sample, it expects only the hold flag, with the setup time measured from the earlier data change. The bench also tests both ways of meeting recovery, with the chip-select strobe high and the write strobe still low, once just at the limit and once one tick short.

// File: rtl/sram_mon_pkg.sv
package sram_mon_pkg;

   localparam int NRULE = 8;

   // rule bit positions (decoded by software reading err_flag)
   localparam int RU_WP = 0;
   localparam int RU_DW = 1;
   localparam int RU_DH = 2;
   localparam int RU_AC = 3;
   localparam int RU_WR = 4;
   localparam int RU_WC = 5;
   localparam int RU_AW = 6;
   localparam int RU_CW = 7;

   // limit selectors
   localparam int LIM_WP  = 0;
   localparam int LIM_DW  = 1;
   localparam int LIM_RWE = 2;
   localparam int LIM_RCE = 3;
   localparam int LIM_WC  = 4;
   localparam int LIM_AW  = 5;
   localparam int LIM_CW  = 6;

   function automatic int min_ns(input int grade, input int which);
      int r;
      r = 0;
      case (which)
         LIM_WP:  case (grade) 0: r = 55; 1: r = 65; 2: r = 90;  default: r = 130; endcase
         LIM_DW:  case (grade) 0: r = 30; 1: r = 35; 2: r = 50;  default: r = 70;  endcase
         LIM_RWE: r = 5;
         LIM_RCE: r = 15;
         LIM_WC:  case (grade) 0: r = 70; 1: r = 85; 2: r = 150; default: r = 200; endcase
         LIM_AW:  case (grade) 0: r = 65; 1: r = 75; 2: r = 90;  default: r = 150; endcase
         LIM_CW:  case (grade) 0: r = 65; 1: r = 75; 2: r = 100; default: r = 150; endcase
         default: r = 0;
      endcase
      return r;
   endfunction

   // round up: a measured tick count below this is always too short
   function automatic int to_ticks(input int ns, input int clk_ps);
      return (ns * 1000 + clk_ps - 1) / clk_ps;
   endfunction

endpackage

// File: rtl/sram_mon_sample.sv
module sram_mon_sample #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic              ce_n_i,
   input  logic              we_n_i,
   output logic              live_o,
   output logic              s_ce_n_o,
   output logic              p_ce_n_o,
   output logic              s_we_n_o,
   output logic              p_we_n_o,
   output logic              addr_chg_o,
   output logic              data_chg_o
);

   logic [ADDR_W-1:0] s_addr_q, p_addr_q;
   logic [DATA_W-1:0] s_data_q, p_data_q;
   logic              s_ce_q, p_ce_q, s_we_q, p_we_q;
   logic [1:0]        fill_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s_addr_q <= '0;
         p_addr_q <= '0;
         s_data_q <= '0;
         p_data_q <= '0;
         s_ce_q   <= 1'b1;
         p_ce_q   <= 1'b1;
         s_we_q   <= 1'b1;
         p_we_q   <= 1'b1;
         fill_q   <= 2'd0;
      end else begin
         s_addr_q <= addr_i;
         p_addr_q <= s_addr_q;
         s_data_q <= data_i;
         p_data_q <= s_data_q;
         s_ce_q   <= ce_n_i;
         p_ce_q   <= s_ce_q;
         s_we_q   <= we_n_i;
         p_we_q   <= s_we_q;
         if (fill_q != 2'd2) fill_q <= fill_q + 2'd1;
      end
   end

   assign live_o     = (fill_q == 2'd2);
   assign s_ce_n_o   = s_ce_q;
   assign p_ce_n_o   = p_ce_q;
   assign s_we_n_o   = s_we_q;
   assign p_we_n_o   = p_we_q;
   assign addr_chg_o = live_o && (s_addr_q != p_addr_q);
   assign data_chg_o = live_o && (s_data_q != p_data_q);

   a_r1_live_holds: assert property (@(posedge clk) disable iff (!rst_n)
      live_o |=> live_o);

endmodule

// File: rtl/sram_mon_window.sv
module sram_mon_window #(
   parameter int TS_W = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            live_i,
   input  logic            s_ce_n_i,
   input  logic            p_ce_n_i,
   input  logic            s_we_n_i,
   input  logic            p_we_n_i,
   input  logic            addr_chg_i,
   input  logic            data_chg_i,
   output logic [TS_W-1:0] tnow_o,
   output logic            win_now_o,
   output logic            win_prev_o,
   output logic            wstart_o,
   output logic            wend_o,
   output logic            ce_rise_o,
   output logic            we_rise_o,
   output logic [TS_W-1:0] ts_start_o,
   output logic [TS_W-1:0] ts_cefall_o,
   output logic [TS_W-1:0] ts_addr_o,
   output logic [TS_W-1:0] ts_data_o,
   output logic [TS_W-1:0] ts_werise_o,
   output logic [TS_W-1:0] ts_cerise_o
);

   logic ce_fall;

   assign win_now_o  = live_i && !s_ce_n_i && !s_we_n_i;
   assign win_prev_o = live_i && !p_ce_n_i && !p_we_n_i;
   assign wstart_o   = win_now_o && !win_prev_o;
   assign wend_o     = win_prev_o && !win_now_o;
   assign ce_fall    = live_i && p_ce_n_i && !s_ce_n_i;
   assign ce_rise_o  = live_i && !p_ce_n_i && s_ce_n_i;
   assign we_rise_o  = live_i && !p_we_n_i && s_we_n_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tnow_o      <= '0;
         ts_start_o  <= '0;
         ts_cefall_o <= '0;
         ts_addr_o   <= '0;
         ts_data_o   <= '0;
         ts_werise_o <= '0;
         ts_cerise_o <= '0;
      end else begin
         tnow_o <= tnow_o + 1'b1;
         if (wstart_o)   ts_start_o  <= tnow_o;
         if (ce_fall)    ts_cefall_o <= tnow_o;
         if (addr_chg_i) ts_addr_o   <= tnow_o;
         if (data_chg_i) ts_data_o   <= tnow_o;
         if (we_rise_o)  ts_werise_o <= tnow_o;
         if (ce_rise_o)  ts_cerise_o <= tnow_o;
      end
   end

   a_r2_open_persists: assert property (@(posedge clk) disable iff (!rst_n)
      wstart_o |=> win_prev_o);

endmodule

// File: rtl/sram_mon_rules.sv
module sram_mon_rules
   import sram_mon_pkg::*;
#(
   parameter int TS_W   = 16,
   parameter int GRADE  = 0,
   parameter int CLK_PS = 5000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [TS_W-1:0]  tnow_i,
   input  logic [TS_W-1:0]  ts_start_i,
   input  logic [TS_W-1:0]  ts_cefall_i,
   input  logic [TS_W-1:0]  ts_addr_i,
   input  logic [TS_W-1:0]  ts_data_i,
   input  logic [TS_W-1:0]  ts_werise_i,
   input  logic [TS_W-1:0]  ts_cerise_i,
   input  logic             win_now_i,
   input  logic             win_prev_i,
   input  logic             wstart_i,
   input  logic             wend_i,
   input  logic             ce_rise_i,
   input  logic             we_rise_i,
   input  logic             s_ce_n_i,
   input  logic             s_we_n_i,
   input  logic             addr_chg_i,
   input  logic             data_chg_i,
   output logic [NRULE-1:0] viol_o,
   output logic [1:0]       end_style_o
);

   localparam int LI_WP  = to_ticks(min_ns(GRADE, LIM_WP),  CLK_PS);
   localparam int LI_DW  = to_ticks(min_ns(GRADE, LIM_DW),  CLK_PS);
   localparam int LI_RWE = to_ticks(min_ns(GRADE, LIM_RWE), CLK_PS);
   localparam int LI_RCE = to_ticks(min_ns(GRADE, LIM_RCE), CLK_PS);
   localparam int LI_WC  = to_ticks(min_ns(GRADE, LIM_WC),  CLK_PS);
   localparam int LI_AW  = to_ticks(min_ns(GRADE, LIM_AW),  CLK_PS);
   localparam int LI_CW  = to_ticks(min_ns(GRADE, LIM_CW),  CLK_PS);

   localparam logic [TS_W-1:0] L_WP  = TS_W'(LI_WP);
   localparam logic [TS_W-1:0] L_DW  = TS_W'(LI_DW);
   localparam logic [TS_W-1:0] L_RWE = TS_W'(LI_RWE);
   localparam logic [TS_W-1:0] L_RCE = TS_W'(LI_RCE);
   localparam logic [TS_W-1:0] L_WC  = TS_W'(LI_WC);
   localparam logic [TS_W-1:0] L_AW  = TS_W'(LI_AW);
   localparam logic [TS_W-1:0] L_CW  = TS_W'(LI_CW);

   if (LI_WC >= (1 << (TS_W - 1))) begin : g_ts_too_narrow
      $error("sram_mon_rules: TS_W cannot hold the longest limit");
   end

   logic [TS_W-1:0] e_start, e_cefall, e_addr, e_data, e_we, e_ce;
   logic            met_we, met_ce, rec_due, cyc_due;
   logic            rec_pend_q, wrote_q;

   assign e_start  = tnow_i - ts_start_i;
   assign e_cefall = tnow_i - ts_cefall_i;
   assign e_addr   = tnow_i - ts_addr_i;
   assign e_data   = tnow_i - ts_data_i;
   assign e_we     = we_rise_i ? '0 : (tnow_i - ts_werise_i);
   assign e_ce     = ce_rise_i ? '0 : (tnow_i - ts_cerise_i);

   assign met_we  = s_we_n_i && (e_we >= L_RWE);
   assign met_ce  = s_ce_n_i && (e_ce >= L_RCE);
   assign rec_due = addr_chg_i && (rec_pend_q || wend_i);
   assign cyc_due = addr_chg_i && (wrote_q || wend_i);

   always_comb begin
      viol_o        = '0;
      viol_o[RU_WP] = wend_i && (e_start  < L_WP);
      viol_o[RU_DW] = wend_i && (e_data   < L_DW);
      viol_o[RU_DH] = wend_i && data_chg_i;
      viol_o[RU_AC] = addr_chg_i && win_now_i && win_prev_i;
      viol_o[RU_WR] = rec_due && !met_we && !met_ce;
      viol_o[RU_WC] = cyc_due && (e_addr < L_WC);
      viol_o[RU_AW] = wend_i && (e_addr   < L_AW);
      viol_o[RU_CW] = wend_i && (e_cefall < L_CW);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rec_pend_q  <= 1'b0;
         wrote_q     <= 1'b0;
         end_style_o <= 2'b00;
      end else begin
         if (addr_chg_i || wstart_i) rec_pend_q <= 1'b0;
         else if (wend_i)            rec_pend_q <= 1'b1;
         if (addr_chg_i)             wrote_q    <= 1'b0;
         else if (wend_i)            wrote_q    <= 1'b1;
         if (wend_i) end_style_o <= {ce_rise_i, we_rise_i};
      end
   end

   a_r2_style_named: assert property (@(posedge clk) disable iff (!rst_n)
      wend_i |=> (end_style_o != 2'b00));

   a_r7_rec_needs_end: assert property (@(posedge clk) disable iff (!rst_n)
      viol_o[RU_WR] |-> !win_now_i);

endmodule

// File: rtl/sram_mon_errlog.sv
module sram_mon_errlog #(
   parameter int NR    = 8,
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic [NR-1:0]    viol_i,
   output logic [NR-1:0]    flag_o,
   output logic [NR-1:0]    pulse_o,
   output logic [CNT_W-1:0] count_o
);

   localparam int NB = $clog2(NR + 1);
   localparam int SW = ((CNT_W > NB) ? CNT_W : NB) + 1;
   localparam logic [CNT_W-1:0] CMAX = '1;

   logic [SW-1:0] sum;

   for (genvar k = 0; k < NR; k++) begin : g_rule
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            flag_o[k]  <= 1'b0;
            pulse_o[k] <= 1'b0;
         end else if (clr_i) begin
            flag_o[k]  <= 1'b0;
            pulse_o[k] <= 1'b0;
         end else begin
            pulse_o[k] <= viol_i[k];
            if (viol_i[k]) flag_o[k] <= 1'b1;
         end
      end

      a_r11_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
         (flag_o[k] && !clr_i) |=> flag_o[k]);

      a_r11_pulse_flagged: assert property (@(posedge clk) disable iff (!rst_n)
         pulse_o[k] |-> flag_o[k]);
   end

   assign sum = SW'(count_o) + SW'($countones(viol_i));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                count_o <= '0;
      else if (clr_i)            count_o <= '0;
      else if (sum > SW'(CMAX))  count_o <= CMAX;
      else                       count_o <= sum[CNT_W-1:0];
   end

   a_r1_clear_wipes: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (flag_o == '0 && pulse_o == '0 && count_o == '0));

   a_r11_count_sat: assert property (@(posedge clk) disable iff (!rst_n)
      (count_o == CMAX && !clr_i) |=> (count_o == CMAX));

endmodule

// File: rtl/sram_wr_timing_mon.sv
module sram_wr_timing_mon
   import sram_mon_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 16,
   parameter int GRADE  = 0,
   parameter int CLK_PS = 5000,
   parameter int TS_W   = 16,
   parameter int CNT_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_data,
   input  logic              bus_ce_n,
   input  logic              bus_we_n,
   output logic [NRULE-1:0]  err_flag,
   output logic [NRULE-1:0]  err_pulse,
   output logic [CNT_W-1:0]  err_count,
   output logic [1:0]        end_style
);

   if (GRADE < 0 || GRADE > 3) begin : g_bad_grade
      $error("sram_wr_timing_mon: GRADE must be 0..3");
   end
   if (CLK_PS < 1) begin : g_bad_clk
      $error("sram_wr_timing_mon: CLK_PS must be positive");
   end
   if (CNT_W < 1 || TS_W < 4 || TS_W > 30) begin : g_bad_width
      $error("sram_wr_timing_mon: counter or timestamp width out of range");
   end

   logic            live, s_ce_n, p_ce_n, s_we_n, p_we_n, addr_chg, data_chg;
   logic [TS_W-1:0] tnow, ts_start, ts_cefall, ts_addr, ts_data, ts_werise, ts_cerise;
   logic            win_now, win_prev, wstart, wend, ce_rise, we_rise;
   logic [NRULE-1:0] viol;

   sram_mon_sample #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_sample (
      .clk(clk), .rst_n(rst_n),
      .addr_i(bus_addr), .data_i(bus_data), .ce_n_i(bus_ce_n), .we_n_i(bus_we_n),
      .live_o(live), .s_ce_n_o(s_ce_n), .p_ce_n_o(p_ce_n),
      .s_we_n_o(s_we_n), .p_we_n_o(p_we_n),
      .addr_chg_o(addr_chg), .data_chg_o(data_chg)
   );

   sram_mon_window #(.TS_W(TS_W)) u_window (
      .clk(clk), .rst_n(rst_n), .live_i(live),
      .s_ce_n_i(s_ce_n), .p_ce_n_i(p_ce_n), .s_we_n_i(s_we_n), .p_we_n_i(p_we_n),
      .addr_chg_i(addr_chg), .data_chg_i(data_chg),
      .tnow_o(tnow), .win_now_o(win_now), .win_prev_o(win_prev),
      .wstart_o(wstart), .wend_o(wend), .ce_rise_o(ce_rise), .we_rise_o(we_rise),
      .ts_start_o(ts_start), .ts_cefall_o(ts_cefall), .ts_addr_o(ts_addr),
      .ts_data_o(ts_data), .ts_werise_o(ts_werise), .ts_cerise_o(ts_cerise)
   );

   sram_mon_rules #(.TS_W(TS_W), .GRADE(GRADE), .CLK_PS(CLK_PS)) u_rules (
      .clk(clk), .rst_n(rst_n), .tnow_i(tnow),
      .ts_start_i(ts_start), .ts_cefall_i(ts_cefall), .ts_addr_i(ts_addr),
      .ts_data_i(ts_data), .ts_werise_i(ts_werise), .ts_cerise_i(ts_cerise),
      .win_now_i(win_now), .win_prev_i(win_prev), .wstart_i(wstart), .wend_i(wend),
      .ce_rise_i(ce_rise), .we_rise_i(we_rise), .s_ce_n_i(s_ce_n), .s_we_n_i(s_we_n),
      .addr_chg_i(addr_chg), .data_chg_i(data_chg),
      .viol_o(viol), .end_style_o(end_style)
   );

   sram_mon_errlog #(.NR(NRULE), .CNT_W(CNT_W)) u_errlog (
      .clk(clk), .rst_n(rst_n), .clr_i(clr), .viol_i(viol),
      .flag_o(err_flag), .pulse_o(err_pulse), .count_o(err_count)
   );

endmodule

// File: tb/sim_sram_wr_timing_mon.sv
`timescale 1ns/1ps
module sim_sram_wr_timing_mon;

   // grade 1 at 5 ns ticks: WP 13, DW 7, rec 1 (WE) / 3 (CE), WC 17, AW 15, CW 15
   localparam int CNT_W = 3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       clr = 1'b0;
   logic [7:0] bus_addr = 8'h00;
   logic [7:0] bus_data = 8'h00;
   logic       bus_ce_n = 1'b1;
   logic       bus_we_n = 1'b1;
   logic [7:0] err_flag, err_pulse;
   logic [CNT_W-1:0] err_count;
   logic [1:0] end_style;

   int checks = 0;
   int errors = 0;
   logic [7:0] na = 8'h10;
   logic [7:0] pulse_seen = 8'h00;

   sram_wr_timing_mon #(.ADDR_W(8), .DATA_W(8), .GRADE(1), .CLK_PS(5000),
                        .TS_W(16), .CNT_W(CNT_W)) u0 (
      .clk(clk), .rst_n(rst_n), .clr(clr),
      .bus_addr(bus_addr), .bus_data(bus_data), .bus_ce_n(bus_ce_n), .bus_we_n(bus_we_n),
      .err_flag(err_flag), .err_pulse(err_pulse), .err_count(err_count), .end_style(end_style)
   );

   always #2.5 clk = ~clk;

   always @(negedge clk) pulse_seen <= pulse_seen | err_pulse;

   task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
      end
   endtask

   task automatic step(input logic [7:0] a, input logic [7:0] d,
                       input logic ce, input logic we, input int n);
      bus_addr = a; bus_data = d; bus_ce_n = ce; bus_we_n = we;
      repeat (n) @(negedge clk);
   endtask

   task automatic fresh(output logic [7:0] a);
      a  = na;
      na = na + 8'd4;
      clr = 1'b1;
      @(negedge clk);
      clr = 1'b0;
      pulse_seen = 8'h00;
      @(negedge clk);
   endtask

   task automatic settle_chk(input string tag, input logic [7:0] exp_flag);
      repeat (3) @(negedge clk);
      chk(tag, err_flag, exp_flag);
      chk({tag, " count"}, 8'(err_count), (exp_flag == 8'h00) ? 8'd0 : 8'd1);
   endtask

   task automatic t_legal_we();
      logic [7:0] a;
      fresh(a);
      step(a, 8'h11, 1, 1, 3); step(a, 8'h11, 0, 1, 1); step(a, 8'h11, 0, 0, 2);
      step(a, 8'h22, 0, 0, 12); step(a, 8'h22, 0, 1, 1); step(a, 8'h22, 1, 1, 3);
      step(a + 8'd1, 8'h22, 1, 1, 3);
      settle_chk("R12 legal WE-ended write", 8'h00);
      chk("R2 style WE-ended", {6'd0, end_style}, 8'h01);
   endtask

   task automatic t_legal_ce();
      logic [7:0] a;
      fresh(a);
      step(a, 8'h31, 1, 1, 3); step(a, 8'h31, 1, 0, 1); step(a, 8'h31, 0, 0, 2);
      step(a, 8'h32, 0, 0, 13); step(a, 8'h32, 1, 0, 4); step(a, 8'h32, 1, 1, 1);
      step(a + 8'd1, 8'h32, 1, 1, 3);
      settle_chk("R12 legal CE-ended write", 8'h00);
      chk("R2 style CE-ended", {6'd0, end_style}, 8'h02);
   endtask

   task automatic t_both_end();
      logic [7:0] a;
      fresh(a);
      step(a, 8'h41, 1, 1, 3); step(a, 8'h41, 0, 0, 1); step(a, 8'h42, 0, 0, 14);
      step(a, 8'h42, 1, 1, 3); step(a + 8'd1, 8'h42, 1, 1, 3);
      settle_chk("R2 joint close legal", 8'h00);
      chk("R2 style both strobes", {6'd0, end_style}, 8'h03);
   endtask

   task automatic t_wp();
      logic [7:0] a;
      fresh(a);
      step(a, 8'h51, 1, 1, 3); step(a, 8'h51, 0, 1, 9); step(a, 8'h51, 0, 0, 10);
      step(a, 8'h51, 0, 1, 1); step(a, 8'h51, 1, 1, 3); step(a + 8'd1, 8'h51, 1, 1, 3);
      settle_chk("R3 short write pulse", 8'h01);
      chk("R11 pulse seen for R3", pulse_seen, 8'h01);
   endtask

   task automatic t_dw();
      logic [7:0] a;
      fresh(a);
      step(a, 8'h61, 1, 1, 3); step(a, 8'h61, 0, 1, 1); step(a, 8'h61, 0, 0, 9);
      step(a, 8'h62, 0, 0, 5); step(a, 8'h62, 0, 1, 1); step(a, 8'h62, 1, 1, 3);
      step(a + 8'd1, 8'h62, 1, 1, 3);
      settle_chk("R4 late data", 8'h02);
   endtask

   task automatic t_dh();
      logic [7:0] a;
      fresh(a);
      step(a, 8'h71, 1, 1, 3); step(a, 8'h71, 0, 1, 1); step(a, 8'h71, 0, 0, 2);
      step(a, 8'h72, 0, 0, 12); step(a, 8'h73, 0, 1, 1); step(a, 8'h73, 1, 1, 3);
      step(a + 8'd1, 8'h73, 1, 1, 3);
      settle_chk("R5 data moves at close", 8'h04);
   endtask

   task automatic t_ac();
      logic [7:0] a;
      fresh(a);
      step(a, 8'h81, 1, 1, 3); step(a, 8'h81, 0, 1, 1); step(a, 8'h81, 0, 0, 1);
      step(a + 8'd1, 8'h82, 0, 0, 15); step(a + 8'd1, 8'h82, 0, 1, 1);
      step(a + 8'd1, 8'h82, 1, 1, 3); step(a + 8'd2, 8'h82, 1, 1, 3);
      settle_chk("R6 address moves inside write", 8'h08);
   endtask

   task automatic t_wr_we();
      logic [7:0] a;
      fresh(a);
      step(a, 8'h91, 1, 1, 3); step(a, 8'h91, 0, 1, 1); step(a, 8'h91, 0, 0, 2);
      step(a, 8'h92, 0, 0, 12); step(a + 8'd1, 8'h92, 0, 1, 1);
      step(a + 8'd1, 8'h92, 1, 1, 3); step(a + 8'd2, 8'h92, 1, 1, 3);
      settle_chk("R7 address moves at WE close", 8'h10);
   endtask

   task automatic t_wr_ce(input int hold, input logic [7:0] exp, input string tag);
      logic [7:0] a;
      fresh(a);
      step(a, 8'hA1, 1, 1, 3); step(a, 8'hA1, 1, 0, 1); step(a, 8'hA1, 0, 0, 2);
      step(a, 8'hA2, 0, 0, 13); step(a, 8'hA2, 1, 0, hold);
      step(a + 8'd1, 8'hA2, 1, 0, 2); step(a + 8'd1, 8'hA2, 1, 1, 3);
      settle_chk(tag, exp);
   endtask

   task automatic t_wc();
      logic [7:0] a;
      fresh(a);
      step(a, 8'hB1, 0, 1, 2); step(a, 8'hB2, 0, 0, 13); step(a, 8'hB2, 0, 1, 1);
      step(a + 8'd1, 8'hB2, 0, 1, 1); step(a + 8'd1, 8'hB2, 1, 1, 3);
      settle_chk("R8 short cycle", 8'h20);
   endtask

   task automatic t_aw();
      logic [7:0] a;
      fresh(a);
      step(a, 8'hC1, 0, 1, 2); step(a + 8'd1, 8'hC2, 0, 1, 1);
      step(a + 8'd1, 8'hC2, 0, 0, 13); step(a + 8'd1, 8'hC2, 0, 1, 1);
      step(a + 8'd1, 8'hC2, 1, 1, 3); step(a + 8'd2, 8'hC2, 1, 1, 3);
      settle_chk("R9 address valid too late", 8'h40);
   endtask

   task automatic t_cw();
      logic [7:0] a;
      fresh(a);
      step(a, 8'hD1, 1, 1, 1); step(a, 8'hD1, 1, 0, 3); step(a, 8'hD1, 0, 0, 13);
      step(a, 8'hD1, 1, 0, 1); step(a, 8'hD1, 1, 1, 3); step(a + 8'd1, 8'hD1, 1, 1, 3);
      settle_chk("R10 chip-select too late", 8'h80);
   endtask

   task automatic t_saturate();
      logic [7:0] a;
      fresh(a);
      for (int i = 0; i < 9; i++) begin
         step(a, 8'hE1, 1, 1, 3); step(a, 8'hE1, 0, 1, 1); step(a, 8'hE1, 0, 0, 2);
         step(a, 8'hE2, 0, 0, 12); step(a, 8'hE3, 0, 1, 1); step(a, 8'hE3, 1, 1, 3);
         a = a + 8'd1;
      end
      step(a, 8'hE3, 1, 1, 3);
      chk("R11 count saturates", 8'(err_count), 8'd7);
      chk("R11 flag stays sticky", err_flag, 8'h04);
      clr = 1'b1;
      @(negedge clk);
      clr = 1'b0;
      chk("R1 clear flags", err_flag, 8'h00);
      chk("R1 clear count", 8'(err_count), 8'd0);
      chk("R1 clear pulse", err_pulse, 8'h00);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk("R1 reset flags", err_flag, 8'h00);
      chk("R1 reset count", 8'(err_count), 8'd0);
      chk("R1 reset style", {6'd0, end_style}, 8'h00);
      t_legal_we();
      t_legal_ce();
      t_both_end();
      t_wp();
      t_dw();
      t_dh();
      t_ac();
      t_wr_we();
      t_wr_ce(3, 8'h00, "R7 CE recovery just met");
      t_wr_ce(2, 8'h10, "R7 CE recovery short");
      t_wc();
      t_aw();
      t_cw();
      t_saturate();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL R12 watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule